// File: doc/BRIEF.md
# HDLC Receive Frame Assembler

This block collects one received HDLC frame from the receive FIFO of a line controller and hands it to the next layer as a byte stream. The controller reports three kinds of event. A pool event means a full pool of 32 bytes is waiting. An end event means the last, possibly partial, pool of a frame is waiting; it comes with a status byte and a byte count. An overflow event means the receiver lost data. For each event the block pops the bytes it accepts from a show-ahead FIFO into an internal frame buffer. It then returns a one-cycle completion acknowledge, which tells the controller it may release that part of its FIFO.

On an end event the status byte is checked before any data is moved. A frame that passes the check and fits in the buffer is streamed out with start, end, valid and length signals. Any other frame is discarded. The parameter `STATUS_TRAILER` selects between two controller variants. The trailer variant checks one extra status flag, appends a status byte to every frame that the block strips off, and reports overflow events. Bit encodings below refer to the status byte `end_status`.

Top module: `hdlc_rx_assembler`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `fifo_pop`, `done_ack`, `frm_valid`, `frm_sof` and `frm_eof` are low.
- R2: A pool event that is accepted pops exactly 32 bytes into the buffer. Exactly one `done_ack` pulse follows the last pop.
- R3: At an end event the status byte is ANDed with 0x70 and must equal 0x20 (bit 5 is CRC good, bit 6 is data overflow, bit 4 is abort). With `STATUS_TRAILER`=1 the mask is 0xF0 and the required value is 0xA0, where bit 7 means a valid frame. On a mismatch there is no pop and no frame, one `done_ack` is given, and the buffer is emptied.
- R4: The byte count of an end event is `end_count` ANDed with 0x1F. A result of 0 stands for 32 bytes, and bits 7..5 are ignored.
- R5: If the buffered length plus the incoming count is MAX_LEN or more, the block does not pop, gives one `done_ack`, empties the buffer and delivers nothing.
- R6: With `STATUS_TRAILER`=1 the last accepted byte is a status byte, so the delivered length is one less than the number of bytes taken. A frame whose delivered length would be 0 is dropped after its bytes are popped.
- R7: With `STATUS_TRAILER`=1 an overflow event gives one `done_ack`, does not pop, and keeps the buffered bytes. With `STATUS_TRAILER`=0 it is ignored and no acknowledge follows.
- R8: After every end event, delivered or dropped, the buffer is empty, so the next frame starts at offset 0.
- R9: A delivered frame is sent in arrival order, one byte per cycle on consecutive cycles. `frm_sof` marks the first byte, `frm_eof` marks the last, and `frm_len` holds the frame length for the whole frame.
- R10: Events are taken only while the block is idle, and events seen while it is busy are lost. When several events arrive in the same cycle, only one is handled: end before pool, pool before overflow. No acknowledge and no pop happen while a frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pool_full_evt | input | 1 | One-cycle pulse: a full pool of 32 bytes is waiting |
| msg_end_evt | input | 1 | One-cycle pulse: the last pool of a frame is waiting |
| overflow_evt | input | 1 | One-cycle pulse: the receiver overflowed |
| end_status | input | 8 | Status byte, sampled with an end event |
| end_count | input | 8 | Byte count, sampled with an end event |
| fifo_rdata | input | 8 | Head byte of the show-ahead receive FIFO |
| fifo_pop | output | 1 | Takes the head byte in this cycle |
| done_ack | output | 1 | One-cycle completion acknowledge |
| frm_valid | output | 1 | Frame byte valid |
| frm_sof | output | 1 | First byte of a frame |
| frm_eof | output | 1 | Last byte of a frame |
| frm_data | output | 8 | Frame byte |
| frm_len | output | clog2(MAX_LEN) | Length of the frame being sent |

## Verification
An event is sampled at a clock edge E. A dropped or overflow event raises `done_ack` in the cycle after E. An event that reads N bytes pops in the N cycles after E and raises `done_ack` in the cycle after the last pop. A delivered frame of L bytes then appears on the L cycles that follow, one byte per cycle. The bench drives each event on a falling edge and allows enough idle cycles for the longest case (32 pops and a 63-byte frame) before comparing. Pops, acknowledges and frame bytes are sampled on falling edges, so they are counted against what the model predicts for that event regardless of where each result falls in the window.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  typedef enum logic [1:0] {
    RX_EV_NONE,
    RX_EV_POOL,
    RX_EV_END,
    RX_EV_OVF
  } rx_evt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_SEND
  } rx_state_e;

  // Exact match of the end-of-frame status flags for the selected variant.
  function automatic logic status_good(input logic [7:0] s, input logic trailer);
    logic [7:0] mask;
    logic [7:0] want;
    mask = trailer ? 8'hF0 : 8'h70;
    want = trailer ? 8'hA0 : 8'h20;
    return (s & mask) == want;
  endfunction

endpackage

// File: rtl/rxa_decide.sv
module rxa_decide
  import rxa_pkg::*;
#(
  parameter int MAX_LEN        = 64,
  parameter int POOL_BYTES     = 32,
  parameter int STATUS_TRAILER = 1,
  parameter int LEN_W          = $clog2(MAX_LEN),
  parameter int CNT_W          = $clog2(POOL_BYTES)
) (
  input  logic             idle,
  input  logic             pool_evt,
  input  logic             end_evt,
  input  logic             ovf_evt,
  input  logic [7:0]       status,
  input  logic [7:0]       count,
  input  logic [LEN_W-1:0] fill,
  output rx_evt_e          kind,
  output logic             do_read,
  output logic [CNT_W:0]   rd_n,
  output logic             ack_now,
  output logic             clear_fill
);
  localparam int SUM_W = $clog2(MAX_LEN + POOL_BYTES) + 1;

  logic             ovf_seen;
  logic [7:0]       cnt_masked;
  logic [SUM_W-1:0] need;
  logic             overrun;
  logic             accept;

  generate
    if (STATUS_TRAILER != 0) begin : g_ovf_on
      assign ovf_seen = ovf_evt;
    end else begin : g_ovf_off
      assign ovf_seen = 1'b0 & ovf_evt;
    end
  endgenerate

  // End beats pool beats overflow; nothing is taken while busy.
  always_comb begin
    kind = RX_EV_NONE;
    if (idle) begin
      if (end_evt)       kind = RX_EV_END;
      else if (pool_evt) kind = RX_EV_POOL;
      else if (ovf_seen) kind = RX_EV_OVF;
    end
  end

  assign cnt_masked = count & 8'(POOL_BYTES - 1);

  always_comb begin
    if (kind == RX_EV_END && cnt_masked != 8'd0)
      rd_n = (CNT_W+1)'(cnt_masked);
    else
      rd_n = (CNT_W+1)'(POOL_BYTES);
  end

  assign need    = SUM_W'(fill) + SUM_W'(rd_n);
  assign overrun = need >= SUM_W'(MAX_LEN);

  assign accept = (kind == RX_EV_POOL) ||
                  (kind == RX_EV_END && status_good(status, STATUS_TRAILER != 0));

  assign do_read    = accept && !overrun;
  assign ack_now    = (kind != RX_EV_NONE) && !do_read;
  assign clear_fill = (kind == RX_EV_POOL || kind == RX_EV_END) && !do_read;

endmodule

// File: rtl/rxa_buf_ram.sv
module rxa_buf_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxa_out_stage.sv
module rxa_out_stage #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             first,
  input  logic             last,
  input  logic [LEN_W-1:0] len_in,
  output logic             valid,
  output logic             sof,
  output logic             eof,
  output logic [LEN_W-1:0] len
);
  // These registers update on the same edge as the RAM read register, so they stay aligned with it.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      sof   <= 1'b0;
      eof   <= 1'b0;
      len   <= '0;
    end else begin
      valid <= issue;
      sof   <= issue & first;
      eof   <= issue & last;
      if (issue) len <= len_in;
    end
  end

endmodule

// File: rtl/hdlc_rx_assembler.sv
module hdlc_rx_assembler
  import rxa_pkg::*;
#(
  parameter int MAX_LEN        = 64,
  parameter int POOL_BYTES     = 32,
  parameter int STATUS_TRAILER = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pool_full_evt,
  input  logic                       msg_end_evt,
  input  logic                       overflow_evt,
  input  logic [7:0]                 end_status,
  input  logic [7:0]                 end_count,
  input  logic [7:0]                 fifo_rdata,
  output logic                       fifo_pop,
  output logic                       done_ack,
  output logic                       frm_valid,
  output logic                       frm_sof,
  output logic                       frm_eof,
  output logic [7:0]                 frm_data,
  output logic [$clog2(MAX_LEN)-1:0] frm_len
);
  localparam int LEN_W = $clog2(MAX_LEN);
  localparam int CNT_W = $clog2(POOL_BYTES);
  localparam logic [LEN_W:0] TRAIL = (LEN_W+1)'(STATUS_TRAILER != 0 ? 1 : 0);

  rx_state_e        st;
  logic [LEN_W-1:0] wr_ptr;
  logic [LEN_W-1:0] rd_ptr;
  logic [LEN_W-1:0] send_len;
  logic [CNT_W:0]   rem;
  logic             cur_end;
  logic             ack_q;

  rx_evt_e          kind;
  logic             do_read;
  logic [CNT_W:0]   rd_n;
  logic             ack_now;
  logic             clear_fill;

  logic [LEN_W:0]   flen;
  logic             send_issue;
  logic             send_last;

  rxa_decide #(
    .MAX_LEN       (MAX_LEN),
    .POOL_BYTES    (POOL_BYTES),
    .STATUS_TRAILER(STATUS_TRAILER),
    .LEN_W         (LEN_W),
    .CNT_W         (CNT_W)
  ) u_decide (
    .idle      (st == ST_IDLE),
    .pool_evt  (pool_full_evt),
    .end_evt   (msg_end_evt),
    .ovf_evt   (overflow_evt),
    .status    (end_status),
    .count     (end_count),
    .fill      (wr_ptr),
    .kind      (kind),
    .do_read   (do_read),
    .rd_n      (rd_n),
    .ack_now   (ack_now),
    .clear_fill(clear_fill)
  );

  assign fifo_pop   = (st == ST_READ);
  assign send_issue = (st == ST_SEND);
  assign send_last  = (rd_ptr == send_len - LEN_W'(1));
  assign flen       = (LEN_W+1)'(wr_ptr) + (LEN_W+1)'(1) - TRAIL;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      send_len <= '0;
      rem      <= '0;
      cur_end  <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (do_read) begin
            st      <= ST_READ;
            rem     <= rd_n;
            cur_end <= (kind == RX_EV_END);
          end else begin
            if (ack_now)    ack_q  <= 1'b1;
            if (clear_fill) wr_ptr <= '0;
          end
        end
        ST_READ: begin
          wr_ptr <= wr_ptr + LEN_W'(1);
          rem    <= rem - (CNT_W+1)'(1);
          if (rem == (CNT_W+1)'(1)) begin
            ack_q <= 1'b1;
            st    <= ST_IDLE;
            if (cur_end) begin
              wr_ptr <= '0;
              if (flen != '0) begin
                st       <= ST_SEND;
                send_len <= flen[LEN_W-1:0];
                rd_ptr   <= '0;
              end
            end
          end
        end
        ST_SEND: begin
          rd_ptr <= rd_ptr + LEN_W'(1);
          if (send_last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done_ack = ack_q;

  rxa_buf_ram #(
    .DEPTH (MAX_LEN),
    .DATA_W(8),
    .ADDR_W(LEN_W)
  ) u_ram (
    .clk  (clk),
    .we   (fifo_pop),
    .waddr(wr_ptr),
    .wdata(fifo_rdata),
    .raddr(rd_ptr),
    .rdata(frm_data)
  );

  rxa_out_stage #(
    .LEN_W(LEN_W)
  ) u_out (
    .clk   (clk),
    .rst   (rst),
    .issue (send_issue),
    .first (rd_ptr == '0),
    .last  (send_last),
    .len_in(send_len),
    .valid (frm_valid),
    .sof   (frm_sof),
    .eof   (frm_eof),
    .len   (frm_len)
  );

endmodule

// File: rtl/hdlc_rx_assembler_chk.sv
module hdlc_rx_assembler_chk #(
  parameter int MAX_LEN    = 64,
  parameter int POOL_BYTES = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       fifo_pop,
  input logic                       done_ack,
  input logic                       frm_valid,
  input logic                       frm_sof,
  input logic                       frm_eof,
  input logic [$clog2(MAX_LEN)-1:0] frm_len
);
  localparam int RUN_W = $clog2(POOL_BYTES + 2) + 1;

  logic [RUN_W-1:0] pop_run;

  always_ff @(posedge clk) begin
    if (rst) pop_run <= '0;
    else     pop_run <= fifo_pop ? pop_run + RUN_W'(1) : '0;
  end

  // R2
  pop_run_chk: assert property (@(posedge clk) disable iff (rst)
    pop_run <= RUN_W'(POOL_BYTES));

  // R2
  ack_after_pop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fifo_pop) |-> done_ack);

  // R10
  no_ack_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_ack && frm_valid));

  // R10
  no_pop_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !(fifo_pop && frm_valid));

  // R9
  sof_valid_chk: assert property (@(posedge clk) disable iff (rst)
    frm_sof |-> frm_valid);

  // R9
  eof_valid_chk: assert property (@(posedge clk) disable iff (rst)
    frm_eof |-> frm_valid);

  // R9
  frame_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_eof) |=> (frm_valid && !frm_sof && $stable(frm_len)));

  // R5
  len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    frm_valid |-> (frm_len != '0));

endmodule

bind hdlc_rx_assembler hdlc_rx_assembler_chk #(
  .MAX_LEN   (MAX_LEN),
  .POOL_BYTES(POOL_BYTES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fifo_pop (fifo_pop),
  .done_ack (done_ack),
  .frm_valid(frm_valid),
  .frm_sof  (frm_sof),
  .frm_eof  (frm_eof),
  .frm_len  (frm_len)
);

// File: tb/tb_hdlc_rx_assembler.sv
module tb_hdlc_rx_assembler;
  localparam int MAXL = 64;
  localparam int POOL = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst;
  logic       pool_evt, end_evt, ovf_evt;
  logic [7:0] stat, cnt;
  logic [7:0] pdat [POOL];
  int         hd [2];
  logic [7:0] rd [2];
  logic       pop [2], ack [2], fv [2], fs [2], fe [2];
  logic [7:0] fd [2];
  logic [5:0] fl [2];
  logic       popd [2];

  int errors = 0, checks = 0;
  bit finished = 0;

  // Index 1 is the trailer variant, index 0 the plain variant.
  hdlc_rx_assembler #(.MAX_LEN(MAXL), .POOL_BYTES(POOL), .STATUS_TRAILER(1)) dut (
    .clk(clk), .rst(rst), .pool_full_evt(pool_evt), .msg_end_evt(end_evt),
    .overflow_evt(ovf_evt), .end_status(stat), .end_count(cnt),
    .fifo_rdata(rd[1]), .fifo_pop(pop[1]), .done_ack(ack[1]), .frm_valid(fv[1]),
    .frm_sof(fs[1]), .frm_eof(fe[1]), .frm_data(fd[1]), .frm_len(fl[1]));

  hdlc_rx_assembler #(.MAX_LEN(MAXL), .POOL_BYTES(POOL), .STATUS_TRAILER(0)) dut_a (
    .clk(clk), .rst(rst), .pool_full_evt(pool_evt), .msg_end_evt(end_evt),
    .overflow_evt(ovf_evt), .end_status(stat), .end_count(cnt),
    .fifo_rdata(rd[0]), .fifo_pop(pop[0]), .done_ack(ack[0]), .frm_valid(fv[0]),
    .frm_sof(fs[0]), .frm_eof(fe[0]), .frm_data(fd[0]), .frm_len(fl[0]));

  assign rd[0] = pdat[hd[0] % POOL];
  assign rd[1] = pdat[hd[1] % POOL];

  // Observed results per variant
  int         ack_n [2], pop_n [2], frm_n [2], got_n [2], got_len [2], fmt_err [2];
  logic [7:0] got [2][MAXL];

  // Model state per variant
  int         idx_m [2];
  logic [7:0] mbuf [2][MAXL];
  int         e_ack [2], e_pop [2], e_frm [2], e_len [2];

  always @(posedge clk) begin
    popd[0] <= pop[0];
    popd[1] <= pop[1];
  end

  always @(negedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (popd[v]) hd[v] = hd[v] + 1;
      if (ack[v]) ack_n[v]++;
      if (pop[v]) pop_n[v]++;
      if (fv[v]) begin
        if (got_n[v] == 0) begin
          if (!fs[v]) fmt_err[v]++;
          got_len[v] = int'(fl[v]);
        end else if (fs[v] || int'(fl[v]) != got_len[v]) fmt_err[v]++;
        if (got_n[v] < MAXL) got[v][got_n[v]] = fd[v];
        got_n[v]++;
        if (fe[v]) begin
          frm_n[v]++;
          if (got_n[v] != got_len[v]) fmt_err[v]++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit st_ok(input int v, input logic [7:0] s);
    if (v == 1) return (s & 8'hF0) == 8'hA0;
    return (s & 8'h70) == 8'h20;
  endfunction

  task automatic model(input int v, input bit p, input bit e, input bit o,
                       input logic [7:0] s, input logic [7:0] c);
    int n;
    e_ack[v] = 0; e_pop[v] = 0; e_frm[v] = 0; e_len[v] = 0;
    if (e) begin
      n = int'(c & 8'h1F);
      if (n == 0) n = 32;
      e_ack[v] = 1;
      if (st_ok(v, s) && idx_m[v] + n < MAXL) begin
        e_pop[v] = n;
        for (int i = 0; i < n; i++) mbuf[v][idx_m[v] + i] = pdat[i];
        e_len[v] = idx_m[v] + n - v;
        e_frm[v] = (e_len[v] >= 1) ? 1 : 0;
      end
      idx_m[v] = 0;
    end else if (p) begin
      e_ack[v] = 1;
      if (idx_m[v] + 32 < MAXL) begin
        e_pop[v] = 32;
        for (int i = 0; i < 32; i++) mbuf[v][idx_m[v] + i] = pdat[i];
        idx_m[v] += 32;
      end else idx_m[v] = 0;
    end else if (o && v == 1) begin
      e_ack[v] = 1;
    end
  endtask

  task automatic do_event(input bit p, input bit e, input bit o,
                          input logic [7:0] s, input logic [7:0] c,
                          input bit late_pool, input string req);
    int bad;
    for (int i = 0; i < POOL; i++) pdat[i] = 8'($urandom);
    for (int v = 0; v < 2; v++) begin
      hd[v] = 0; ack_n[v] = 0; pop_n[v] = 0; frm_n[v] = 0;
      got_n[v] = 0; fmt_err[v] = 0;
      model(v, p, e, o, s, c);
    end
    @(negedge clk);
    pool_evt = p; end_evt = e; ovf_evt = o; stat = s; cnt = c;
    @(negedge clk);
    pool_evt = 0; end_evt = 0; ovf_evt = 0;
    if (late_pool) begin
      repeat (3) @(negedge clk);
      pool_evt = 1;
      @(negedge clk);
      pool_evt = 0;
    end
    repeat (110) @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      chk(ack_n[v] == e_ack[v], req, $sformatf("v%0d acks", v), ack_n[v], e_ack[v]);
      chk(pop_n[v] == e_pop[v], req, $sformatf("v%0d pops", v), pop_n[v], e_pop[v]);
      chk(frm_n[v] == e_frm[v], req, $sformatf("v%0d frames", v), frm_n[v], e_frm[v]);
      if (e_frm[v] == 1) begin
        chk(got_n[v] == e_len[v], req, $sformatf("v%0d bytes", v), got_n[v], e_len[v]);
        chk(got_len[v] == e_len[v], req, $sformatf("v%0d frm_len", v), got_len[v], e_len[v]);
        bad = 0;
        for (int i = 0; i < e_len[v] && i < MAXL; i++)
          if (got[v][i] !== mbuf[v][i]) bad++;
        chk(bad == 0, req, $sformatf("v%0d data mismatches", v), bad, 0);
        chk(fmt_err[v] == 0, "R9", $sformatf("v%0d sof/eof/len framing", v), fmt_err[v], 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k, sel;
    logic [7:0] s;
    void'($urandom(32'd1234));
    hd[0] = 0; hd[1] = 0;
    for (int i = 0; i < POOL; i++) pdat[i] = 8'h00;
    idx_m[0] = 0; idx_m[1] = 0;
    pool_evt = 0; end_evt = 0; ovf_evt = 0; stat = 0; cnt = 0;
    rst = 1;
    repeat (4) @(negedge clk);
    for (int v = 0; v < 2; v++)
      chk(!pop[v] && !ack[v] && !fv[v] && !fs[v] && !fe[v], "R1",
          $sformatf("v%0d outputs in reset", v), int'({pop[v], ack[v], fv[v]}), 0);
    rst = 0;
    @(negedge clk);
    for (int v = 0; v < 2; v++)
      chk(!pop[v] && !ack[v] && !fv[v], "R1",
          $sformatf("v%0d outputs after reset", v), int'({pop[v], ack[v], fv[v]}), 0);

    // R4: count field 0 means 32, upper bits ignored
    do_event(0, 1, 0, 8'hA0, 8'hE0, 0, "R4");
    do_event(0, 1, 0, 8'hA0, 8'hE5, 0, "R4");
    // R2 then R6: pool followed by a short end
    do_event(1, 0, 0, 8'h00, 8'h00, 0, "R2");
    do_event(0, 1, 0, 8'hA0, 8'h01, 0, "R6");
    // R6: trailer variant drops a one-byte frame
    do_event(0, 1, 0, 8'hA0, 8'h01, 0, "R6");
    // R3: status variants
    do_event(0, 1, 0, 8'h20, 8'h04, 0, "R3");
    do_event(0, 1, 0, 8'hB0, 8'h04, 0, "R3");
    do_event(0, 1, 0, 8'hE0, 8'h04, 0, "R3");
    do_event(0, 1, 0, 8'h2F, 8'h04, 0, "R3");
    // R5: second pool overruns, then R8 next frame starts fresh
    do_event(1, 0, 0, 8'h00, 8'h00, 0, "R2");
    do_event(1, 0, 0, 8'h00, 8'h00, 0, "R5");
    do_event(0, 1, 0, 8'hA0, 8'h03, 0, "R8");
    // R5: end overrun after a pool
    do_event(1, 0, 0, 8'h00, 8'h00, 0, "R2");
    do_event(0, 1, 0, 8'hA0, 8'h00, 0, "R5");
    // R3 drop empties the buffer (R8)
    do_event(1, 0, 0, 8'h00, 8'h00, 0, "R2");
    do_event(0, 1, 0, 8'h00, 8'h02, 0, "R3");
    do_event(0, 1, 0, 8'hA0, 8'h05, 0, "R8");
    // R7: overflow keeps buffered bytes
    do_event(1, 0, 0, 8'h00, 8'h00, 0, "R7");
    do_event(0, 0, 1, 8'h00, 8'h00, 0, "R7");
    do_event(0, 1, 0, 8'hA0, 8'h02, 0, "R7");
    // R10: simultaneous events and an event while busy
    do_event(1, 1, 1, 8'hA0, 8'h06, 0, "R10");
    do_event(1, 0, 1, 8'h00, 8'h00, 0, "R10");
    do_event(0, 1, 0, 8'hA0, 8'h08, 1, "R10");

    // Random mix
    for (int it = 0; it < 40; it++) begin
      k = int'($urandom % 10);
      sel = int'($urandom % 3);
      s = (sel == 0) ? 8'hA0 : (sel == 1) ? 8'h20 : 8'($urandom);
      if (k < 4)      do_event(1, 0, 0, s, 8'($urandom), 0, "R2");
      else if (k < 8) do_event(0, 1, 0, s, 8'($urandom), 0, "R3");
      else            do_event(0, 0, 1, s, 8'($urandom), 0, "R7");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule